// File: doc/BRIEF.md
# Queue-Side Early Load Unit

This unit lets load instructions fetch their data while they are still waiting in the instruction queue that separates fetch from decode in an in-order pipeline. A small decoder classifies each instruction as it is pushed into the queue. Loads become candidates, and every queue slot gets a shadow entry in the unit holding the decoded fields and an early-load state. When the load/store unit has a free cycle, the oldest candidate whose operands are safe reads its base register, and its index register when it uses one. The unit forms the effective address and sends a tagged read to the data cache. The returned word is held in the slot's entry.

Safety checks guard both ends of this speculation. A candidate does not start while an older instruction, either already issued or still queued ahead of it, will write one of its address registers, or while a store to the same address executes in that cycle. An access that is pending or finished is marked invalid when an address register is written back or when a store hits its address. When the load leaves the queue, the unit forwards the buffered word only if the entry still holds valid data. Otherwise the load runs through the normal memory stage. A pipeline flush discards every entry.

Top module: `early_load_unit`

## Requirements
- R1: An instruction word is split, from bit 0 upwards, into an IMM_W-bit immediate, index register, base register and destination register (REG_W bits each), a subtract bit, and a 2-bit opcode at the top. Opcode 0 writes no register and opcode 1 writes its destination. Opcode 2 is a load with an immediate offset and opcode 3 is a load with a register offset. Both loads write their destination and are early-load candidates; with IDX_EN=0 only opcode 2 is a candidate.
- R2: The request address is the base register value plus the offset, or minus it when the subtract bit is set. The offset is the zero-extended immediate or the index register value. The result is truncated to AW bits.
- R3: A request is raised only in a cycle with lsu_busy low and flush low, at most one per cycle. It goes to the eligible entry closest to the queue head, and the slot being issued in that cycle is not eligible.
- R4: An entry is not started if an issued, not yet written-back register writer targets its base or used index register, or if an older queued writer does. It is also not started if st_valid presents its effective address in that cycle.
- R5: req_tag is {epoch, slot}, where a slot's epoch counter (EPOCH_W bits) rises by one on every allocation of that slot. A response makes the entry data-valid only if the entry is pending and the tag matches.
- R6: A pending or data-valid entry becomes invalid when wb_valid names its base or used index register, or when st_valid presents its effective address. Invalidation overrides a response in the same cycle. An invalid entry is never restarted.
- R7: On issue of the head slot, fwd_valid is high and fwd_data is the buffered word only when that entry is data-valid and is not invalidated in the same cycle.
- R8: While flush is high, no request or forward is made and allocation and issue are ignored. After the flush the queue is empty and no writer is counted as in flight.
- R9: After reset the queue is empty, all epochs are zero and no request or forward is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Pipeline flush |
| alloc_valid | input | 1 | Instruction pushed into the queue tail |
| alloc_insn | input | INSN_W | Pushed instruction word |
| issue_valid | input | 1 | Queue head leaves to decode |
| lsu_busy | input | 1 | Load/store unit used by the normal pipeline |
| rf_ra_base | output | REG_W | Register file read address, base |
| rf_ra_idx | output | REG_W | Register file read address, index |
| rf_rdata_base | input | DW | Base register value |
| rf_rdata_idx | input | DW | Index register value |
| req_valid | output | 1 | Early cache read request |
| req_addr | output | AW | Request address |
| req_tag | output | EPOCH_W+log2(QDEPTH) | Request tag {epoch, slot} |
| rsp_valid | input | 1 | Cache response valid |
| rsp_tag | input | EPOCH_W+log2(QDEPTH) | Response tag |
| rsp_data | input | DW | Response data |
| wb_valid | input | 1 | Register write-back by an issued instruction |
| wb_reg | input | REG_W | Written register |
| st_valid | input | 1 | Store executing |
| st_addr | input | AW | Store address |
| fwd_valid | output | 1 | Buffered load data handed on at issue |
| fwd_data | output | DW | Buffered load data |

## Verification
The bench builds the unit with QDEPTH=4, NREG=8, AW=8, DW=16 and EPOCH_W=2. The shallow queue fills and wraps often, so head-relative ordering is exercised and stale responses meet reused slots after the epoch has wrapped. The narrow address space makes random stores hit buffered loads often. Eight registers make base and index conflicts with older writers common, so both the start-suppression and the invalidation paths are reached many times alongside clean forwards.

// File: rtl/elu_pkg.sv
package elu_pkg;
   typedef enum logic [1:0] {
      EL_NONE  = 2'd0,
      EL_PEND  = 2'd1,
      EL_VALID = 2'd2,
      EL_INVAL = 2'd3
   } el_state_e;

   localparam logic [1:0] OP_NOWR = 2'd0;
   localparam logic [1:0] OP_ALU  = 2'd1;
   localparam logic [1:0] OP_LDI  = 2'd2;
   localparam logic [1:0] OP_LDR  = 2'd3;
endpackage

// File: rtl/elu_predecode.sv
module elu_predecode #(
   parameter int REG_W  = 3,
   parameter int IMM_W  = 4,
   parameter bit IDX_EN = 1'b1,
   localparam int INSN_W = 3 + 3*REG_W + IMM_W
) (
   input  logic [INSN_W-1:0] insn,
   output logic              is_load,
   output logic              use_idx,
   output logic              sub,
   output logic              writes,
   output logic [REG_W-1:0]  rd,
   output logic [REG_W-1:0]  base,
   output logic [REG_W-1:0]  idx,
   output logic [IMM_W-1:0]  imm
);
   import elu_pkg::*;

   localparam int IDX_LSB  = IMM_W;
   localparam int BASE_LSB = IMM_W + REG_W;
   localparam int RD_LSB   = IMM_W + 2*REG_W;
   localparam int SUB_BIT  = IMM_W + 3*REG_W;
   localparam int OP_LSB   = SUB_BIT + 1;

   logic [1:0] op;

   // R1: field layout
   assign op   = insn[OP_LSB +: 2];
   assign sub  = insn[SUB_BIT];
   assign rd   = insn[RD_LSB +: REG_W];
   assign base = insn[BASE_LSB +: REG_W];
   assign idx  = insn[IDX_LSB +: REG_W];
   assign imm  = insn[IMM_W-1:0];
   assign writes = (op != OP_NOWR);

   generate
      if (IDX_EN) begin : g_idx
         assign is_load = (op == OP_LDI) || (op == OP_LDR);
         assign use_idx = (op == OP_LDR);
      end else begin : g_noidx
         assign is_load = (op == OP_LDI);
         assign use_idx = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/elu_scoreboard.sv
module elu_scoreboard #(
   parameter int NREG  = 8,
   parameter int CNT_W = 3,
   localparam int REG_W = $clog2(NREG)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   input  logic [REG_W-1:0] inc_reg,
   input  logic             dec,
   input  logic [REG_W-1:0] dec_reg,
   output logic [NREG-1:0]  busy
);
   generate
      for (genvar r = 0; r < NREG; r++) begin : g_reg
         logic [CNT_W-1:0] cnt;
         logic             up, dn;
         assign up = inc && (inc_reg == REG_W'(r));
         assign dn = dec && (dec_reg == REG_W'(r)) && (cnt != '0);
         always_ff @(posedge clk) begin
            if (!rst_n || clr)   cnt <= '0;
            else if (up && !dn)  cnt <= cnt + 1'b1;
            else if (dn && !up)  cnt <= cnt - 1'b1;
         end
         assign busy[r] = (cnt != '0);
      end
   endgenerate
endmodule

// File: rtl/elu_pick.sv
module elu_pick #(
   parameter int QDEPTH = 8,
   localparam int QW = $clog2(QDEPTH)
) (
   input  logic [QDEPTH-1:0] elig,
   input  logic [QW-1:0]     head,
   output logic              found,
   output logic [QW-1:0]     sel
);
   logic [QW-1:0] slot;

   // R3: oldest eligible entry, scanning from the queue head
   always_comb begin
      found = 1'b0;
      sel   = head;
      slot  = head;
      for (int k = 0; k < QDEPTH; k++) begin
         slot = head + QW'(k);
         if (!found && elig[slot]) begin
            found = 1'b1;
            sel   = slot;
         end
      end
   end
endmodule

// File: rtl/early_load_unit.sv
module early_load_unit #(
   parameter int QDEPTH  = 8,
   parameter int NREG    = 8,
   parameter int AW      = 16,
   parameter int DW      = 32,
   parameter int IMM_W   = 4,
   parameter int EPOCH_W = 2,
   parameter int CNT_W   = 3,
   parameter bit IDX_EN  = 1'b1,
   localparam int QW     = $clog2(QDEPTH),
   localparam int REG_W  = $clog2(NREG),
   localparam int INSN_W = 3 + 3*REG_W + IMM_W,
   localparam int TAG_W  = EPOCH_W + QW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              alloc_valid,
   input  logic [INSN_W-1:0] alloc_insn,
   input  logic              issue_valid,
   input  logic              lsu_busy,
   output logic [REG_W-1:0]  rf_ra_base,
   output logic [REG_W-1:0]  rf_ra_idx,
   input  logic [DW-1:0]     rf_rdata_base,
   input  logic [DW-1:0]     rf_rdata_idx,
   output logic              req_valid,
   output logic [AW-1:0]     req_addr,
   output logic [TAG_W-1:0]  req_tag,
   input  logic              rsp_valid,
   input  logic [TAG_W-1:0]  rsp_tag,
   input  logic [DW-1:0]     rsp_data,
   input  logic              wb_valid,
   input  logic [REG_W-1:0]  wb_reg,
   input  logic              st_valid,
   input  logic [AW-1:0]     st_addr,
   output logic              fwd_valid,
   output logic [DW-1:0]     fwd_data
);
   import elu_pkg::*;

   generate
      if (QDEPTH < 2 || (1 << QW) != QDEPTH) begin : g_bad_depth
         $error("QDEPTH must be a power of two of at least 2");
      end
      if (NREG < 2 || (1 << REG_W) != NREG) begin : g_bad_nreg
         $error("NREG must be a power of two of at least 2");
      end
      if (DW < AW || DW < IMM_W) begin : g_bad_width
         $error("DW must cover AW and IMM_W");
      end
      if (EPOCH_W < 1 || CNT_W < 1) begin : g_bad_cnt
         $error("EPOCH_W and CNT_W must be positive");
      end
   endgenerate

   // per-slot shadow entries
   logic [QDEPTH-1:0] e_v, e_ld, e_uidx, e_sub, e_wr;
   logic [REG_W-1:0]  e_rd   [QDEPTH];
   logic [REG_W-1:0]  e_base [QDEPTH];
   logic [REG_W-1:0]  e_idx  [QDEPTH];
   logic [IMM_W-1:0]  e_imm  [QDEPTH];
   logic [AW-1:0]     e_ea   [QDEPTH];
   logic [DW-1:0]     e_dat  [QDEPTH];
   logic [EPOCH_W-1:0] e_ep  [QDEPTH];
   el_state_e         e_st   [QDEPTH];
   logic [QW-1:0]     head, tail;

   // decode at allocation
   logic              d_ld, d_uidx, d_sub, d_wr;
   logic [REG_W-1:0]  d_rd, d_base, d_idx;
   logic [IMM_W-1:0]  d_imm;

   elu_predecode #(.REG_W(REG_W), .IMM_W(IMM_W), .IDX_EN(IDX_EN)) u_dec (
      .insn(alloc_insn), .is_load(d_ld), .use_idx(d_uidx), .sub(d_sub),
      .writes(d_wr), .rd(d_rd), .base(d_base), .idx(d_idx), .imm(d_imm)
   );

   // in-flight writer scoreboard
   logic [NREG-1:0] sb_busy;
   logic            do_issue, do_alloc;

   assign do_issue = issue_valid && !flush && e_v[head];
   assign do_alloc = alloc_valid && !flush;

   elu_scoreboard #(.NREG(NREG), .CNT_W(CNT_W)) u_sb (
      .clk(clk), .rst_n(rst_n), .clr(flush),
      .inc(do_issue && e_wr[head]), .inc_reg(e_rd[head]),
      .dec(wb_valid), .dec_reg(wb_reg),
      .busy(sb_busy)
   );

   // per-entry hazard and eligibility logic
   logic [QW-1:0]     age [QDEPTH];
   logic [QDEPTH-1:0] older_wr, inv_hit, rsp_hit, elig;

   generate
      for (genvar i = 0; i < QDEPTH; i++) begin : g_ent
         logic ow;
         assign age[i] = QW'(i) - head;
         // R4: older queued writer of an address register
         always_comb begin
            ow = 1'b0;
            for (int j = 0; j < QDEPTH; j++) begin
               if (e_v[j] && e_wr[j] && (age[j] < age[i]) &&
                   ((e_rd[j] == e_base[i]) || (e_uidx[i] && (e_rd[j] == e_idx[i]))))
                  ow = 1'b1;
            end
         end
         assign older_wr[i] = ow;
         // R6: register write-back or store alias
         assign inv_hit[i] =
            (wb_valid && ((wb_reg == e_base[i]) || (e_uidx[i] && (wb_reg == e_idx[i])))) ||
            (st_valid && (st_addr == e_ea[i]));
         // R5: tag match
         assign rsp_hit[i] = rsp_valid && (rsp_tag == {e_ep[i], QW'(i)});
         assign elig[i] = e_v[i] && e_ld[i] && (e_st[i] == EL_NONE) &&
                          !sb_busy[e_base[i]] &&
                          !(e_uidx[i] && sb_busy[e_idx[i]]) &&
                          !older_wr[i] &&
                          !(issue_valid && (head == QW'(i)));
      end
   endgenerate

   logic          found;
   logic [QW-1:0] sel;

   elu_pick #(.QDEPTH(QDEPTH)) u_pick (
      .elig(elig), .head(head), .found(found), .sel(sel)
   );

   // R2: effective address of the chosen entry
   logic [DW-1:0] off_val;
   logic [AW-1:0] ea_new;
   logic          start;

   assign rf_ra_base = e_base[sel];
   assign rf_ra_idx  = e_idx[sel];
   assign off_val    = e_uidx[sel] ? rf_rdata_idx : DW'(e_imm[sel]);
   assign ea_new     = AW'(e_sub[sel] ? (rf_rdata_base - off_val)
                                      : (rf_rdata_base + off_val));
   assign start      = found && !lsu_busy && !flush &&
                       !(st_valid && (st_addr == ea_new));

   assign req_valid = start;
   assign req_addr  = ea_new;
   assign req_tag   = {e_ep[sel], sel};

   // R7: forward at issue
   assign fwd_valid = do_issue && (e_st[head] == EL_VALID) && !inv_hit[head];
   assign fwd_data  = fwd_valid ? e_dat[head] : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head <= '0;
         tail <= '0;
         for (int i = 0; i < QDEPTH; i++) begin
            e_v[i]    <= 1'b0;
            e_ld[i]   <= 1'b0;
            e_uidx[i] <= 1'b0;
            e_sub[i]  <= 1'b0;
            e_wr[i]   <= 1'b0;
            e_rd[i]   <= '0;
            e_base[i] <= '0;
            e_idx[i]  <= '0;
            e_imm[i]  <= '0;
            e_ea[i]   <= '0;
            e_dat[i]  <= '0;
            e_ep[i]   <= '0;
            e_st[i]   <= EL_NONE;
         end
      end else if (flush) begin
         // R8: drop every entry, keep epochs
         head <= '0;
         tail <= '0;
         for (int i = 0; i < QDEPTH; i++) begin
            e_v[i]  <= 1'b0;
            e_st[i] <= EL_NONE;
         end
      end else begin
         for (int i = 0; i < QDEPTH; i++) begin
            if (((e_st[i] == EL_PEND) || (e_st[i] == EL_VALID)) && inv_hit[i]) begin
               e_st[i] <= EL_INVAL;
            end else if ((e_st[i] == EL_PEND) && rsp_hit[i]) begin
               e_st[i]  <= EL_VALID;
               e_dat[i] <= rsp_data;
            end
            if (start && (sel == QW'(i))) begin
               e_st[i] <= EL_PEND;
               e_ea[i] <= ea_new;
            end
            if (do_issue && (head == QW'(i))) begin
               e_v[i]  <= 1'b0;
               e_st[i] <= EL_NONE;
            end
            if (do_alloc && (tail == QW'(i))) begin
               e_v[i]    <= 1'b1;
               e_ld[i]   <= d_ld;
               e_uidx[i] <= d_uidx;
               e_sub[i]  <= d_sub;
               e_wr[i]   <= d_wr;
               e_rd[i]   <= d_rd;
               e_base[i] <= d_base;
               e_idx[i]  <= d_idx;
               e_imm[i]  <= d_imm;
               e_st[i]   <= EL_NONE;
               e_ep[i]   <= e_ep[i] + 1'b1;
            end
         end
         head <= head + QW'(do_issue);
         tail <= tail + QW'(do_alloc);
      end
   end
endmodule

// File: rtl/elu_chk.sv
module elu_chk #(
   parameter int AW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          flush,
   input logic          lsu_busy,
   input logic          issue_valid,
   input logic          req_valid,
   input logic [AW-1:0] req_addr,
   input logic          st_valid,
   input logic [AW-1:0] st_addr,
   input logic          fwd_valid
);
   AST_REQ_IDLE_LSU: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> !lsu_busy); // R3
   AST_REQ_NO_ST_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && st_valid) |-> (req_addr != st_addr)); // R4
   AST_FWD_AT_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_valid |-> issue_valid); // R7
   AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> (!req_valid && !fwd_valid)); // R8
   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !req_valid); // R8
endmodule

bind early_load_unit elu_chk #(.AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .flush(flush), .lsu_busy(lsu_busy),
   .issue_valid(issue_valid), .req_valid(req_valid), .req_addr(req_addr),
   .st_valid(st_valid), .st_addr(st_addr), .fwd_valid(fwd_valid)
);

// File: tb/early_load_unit_tb.sv
module early_load_unit_tb;
   localparam int Q = 4, NREG = 8, AW = 8, DW = 16, IMM_W = 4, EPOCH_W = 2;
   localparam int REG_W = 3, QW = 2, INSN_W = 3 + 3*REG_W + IMM_W, TAG_W = EPOCH_W + QW;
   localparam int NCYC = 20000;

   logic clk = 1'b0, rst_n = 1'b0;
   always #2 clk = ~clk;

   logic flush = 0, alloc_valid = 0, issue_valid = 0, lsu_busy = 0;
   logic rsp_valid = 0, wb_valid = 0, st_valid = 0;
   logic [INSN_W-1:0] alloc_insn = '0;
   logic [TAG_W-1:0]  rsp_tag = '0;
   logic [DW-1:0]     rsp_data = '0;
   logic [REG_W-1:0]  wb_reg = '0;
   logic [AW-1:0]     st_addr = '0;
   logic [REG_W-1:0]  ra_b, ra_i;
   logic [DW-1:0]     rd_b, rd_i;
   logic              req_valid, fwd_valid;
   logic [AW-1:0]     req_addr;
   logic [TAG_W-1:0]  req_tag;
   logic [DW-1:0]     fwd_data;
   logic [DW-1:0]     regs [NREG];

   assign rd_b = regs[ra_b];
   assign rd_i = regs[ra_i];

   early_load_unit #(.QDEPTH(Q), .NREG(NREG), .AW(AW), .DW(DW), .IMM_W(IMM_W),
                     .EPOCH_W(EPOCH_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .flush(flush), .alloc_valid(alloc_valid),
      .alloc_insn(alloc_insn), .issue_valid(issue_valid), .lsu_busy(lsu_busy),
      .rf_ra_base(ra_b), .rf_ra_idx(ra_i), .rf_rdata_base(rd_b), .rf_rdata_idx(rd_i),
      .req_valid(req_valid), .req_addr(req_addr), .req_tag(req_tag),
      .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data),
      .wb_valid(wb_valid), .wb_reg(wb_reg), .st_valid(st_valid), .st_addr(st_addr),
      .fwd_valid(fwd_valid), .fwd_data(fwd_data)
   );

   int nchk = 0, nfail = 0;

   // reference model state
   int m_op[Q], m_sub[Q], m_rd[Q], m_base[Q], m_idx[Q], m_imm[Q];
   int m_ea[Q], m_st[Q], m_dat[Q], m_ep[Q];
   int m_head = 0, m_cnt = 0;
   int infl[$];
   int pv[2], ptag[2], paddr[2];
   int pw_v = 0, pw_r = 0, pw_val = 0;

   task automatic check(input bit ok, input string what, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   function automatic int cdata(input int a);
      return (a * 37 + 5) % (1 << DW);
   endfunction

   function automatic bit busy(input int r);
      foreach (infl[k]) if (infl[k] == r) return 1'b1;
      return 1'b0;
   endfunction

   // R1: decode fields from an instruction word
   function automatic void decode(input int w, output int op, output int sb, output int rd,
                                  output int bs, output int ix, output int im);
      im = w % (1 << IMM_W);
      ix = (w >> IMM_W) % NREG;
      bs = (w >> (IMM_W + REG_W)) % NREG;
      rd = (w >> (IMM_W + 2*REG_W)) % NREG;
      sb = (w >> (IMM_W + 3*REG_W)) % 2;
      op = (w >> (IMM_W + 3*REG_W + 1)) % 4;
   endfunction

   function automatic bit hit(input int j);
      bit r = 0;
      if (wb_valid && (wb_reg == m_base[j] || (m_op[j] == 3 && wb_reg == m_idx[j]))) r = 1;
      if (st_valid && st_addr == m_ea[j]) r = 1;
      return r;
   endfunction

   function automatic bit elig(input int j, input int k);
      if (m_op[j] < 2 || m_st[j] != 0) return 0;
      if (busy(m_base[j]) || (m_op[j] == 3 && busy(m_idx[j]))) return 0;
      if (issue_valid && k == 0) return 0;
      for (int a = 0; a < k; a++) begin
         int o = (m_head + a) % Q;
         if (m_op[o] != 0 && (m_rd[o] == m_base[j] || (m_op[j] == 3 && m_rd[o] == m_idx[j])))
            return 0;
      end
      return 1;
   endfunction

   task automatic model_step();
      int tl = (m_head + m_cnt) % Q;
      bit found = 0, start, fwd;
      int sel = 0, ea = 0, off;
      for (int k = 0; k < m_cnt; k++) begin
         int j = (m_head + k) % Q;
         if (!found && elig(j, k)) begin found = 1; sel = j; end
      end
      if (found) begin
         off = (m_op[sel] == 3) ? int'(regs[m_idx[sel]]) : m_imm[sel];
         ea  = m_sub[sel] ? int'(regs[m_base[sel]]) - off : int'(regs[m_base[sel]]) + off;
         ea  = ea & ((1 << AW) - 1);
      end
      start = found && !lsu_busy && !flush && !(st_valid && st_addr == ea);
      check(req_valid == start, "R1 R3 R4 R8 req_valid", req_valid, start);
      if (start && req_valid) begin
         check(req_addr == ea, "R2 req_addr", req_addr, ea);
         check(req_tag == m_ep[sel] * Q + sel, "R5 req_tag", req_tag, m_ep[sel] * Q + sel);
      end
      fwd = issue_valid && !flush && m_cnt > 0 && m_st[m_head] == 2 && !hit(m_head);
      check(fwd_valid == fwd, "R5 R6 R7 R8 fwd_valid", fwd_valid, fwd);
      if (fwd && fwd_valid)
         check(fwd_data == m_dat[m_head], "R6 R7 fwd_data", fwd_data, m_dat[m_head]);

      // cache pipeline, two cycles
      pv[1] = pv[0]; ptag[1] = ptag[0]; paddr[1] = paddr[0];
      pv[0] = start; ptag[0] = m_ep[sel] * Q + sel; paddr[0] = ea;

      if (flush) begin
         for (int i = 0; i < Q; i++) m_st[i] = 0;
         m_head = 0; m_cnt = 0;
         infl.delete();
         return;
      end
      for (int k = 0; k < m_cnt; k++) begin
         int j = (m_head + k) % Q;
         if ((m_st[j] == 1 || m_st[j] == 2) && hit(j)) m_st[j] = 3;
         else if (m_st[j] == 1 && rsp_valid && rsp_tag == m_ep[j] * Q + j) begin
            m_st[j] = 2; m_dat[j] = rsp_data;
         end
      end
      if (start) begin m_st[sel] = 1; m_ea[sel] = ea; end
      if (wb_valid) begin
         void'(infl.pop_front());
         pw_v = 1; pw_r = wb_reg; pw_val = $urandom % (1 << DW);
      end
      if (issue_valid) begin
         if (m_op[m_head] != 0) infl.push_back(m_rd[m_head]);
         m_st[m_head] = 0;
         m_head = (m_head + 1) % Q; m_cnt--;
      end
      if (alloc_valid) begin
         decode(alloc_insn, m_op[tl], m_sub[tl], m_rd[tl], m_base[tl], m_idx[tl], m_imm[tl]);
         m_st[tl] = 0; m_ea[tl] = 0;
         m_ep[tl] = (m_ep[tl] + 1) % (1 << EPOCH_W);
         m_cnt++;
      end
   endtask

   initial begin
      #(4 * 150000);
      nfail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      for (int r = 0; r < NREG; r++) regs[r] = DW'(r * 11 + 3);
      for (int i = 0; i < Q; i++) begin
         m_op[i] = 0; m_st[i] = 0; m_ep[i] = 0; m_ea[i] = 0; m_dat[i] = 0;
         m_sub[i] = 0; m_rd[i] = 0; m_base[i] = 0; m_idx[i] = 0; m_imm[i] = 0;
      end
      pv[0] = 0; pv[1] = 0; ptag[0] = 0; ptag[1] = 0; paddr[0] = 0; paddr[1] = 0;
      // R9: quiet outputs during reset
      for (int c = 0; c < 3; c++) begin
         @(posedge clk); #1;
         alloc_valid = 1; alloc_insn = INSN_W'($urandom);
         #1;
         check(!req_valid, "R9 req_valid in reset", req_valid, 0);
         check(!fwd_valid, "R9 fwd_valid in reset", fwd_valid, 0);
      end
      alloc_valid = 0;
      @(posedge clk); #1;
      rst_n = 1;
      for (int c = 0; c < NCYC; c++) begin
         @(posedge clk); #1;
         if (pw_v != 0) regs[pw_r] = DW'(pw_val);
         pw_v = 0;
         flush       = ($urandom % 80) == 0;
         rsp_valid   = pv[1][0];
         rsp_tag     = TAG_W'(ptag[1]);
         rsp_data    = DW'(cdata(paddr[1]));
         alloc_valid = !flush && m_cnt < Q && ($urandom % 3) != 0;
         alloc_insn  = INSN_W'($urandom);
         issue_valid = !flush && m_cnt > 0 && ($urandom % 3) == 0;
         lsu_busy    = ($urandom % 3) == 0;
         wb_valid    = !flush && infl.size() > 0 && ($urandom % 2) == 1;
         wb_reg      = wb_valid ? REG_W'(infl[0]) : '0;
         st_valid    = !flush && ($urandom % 5) == 0;
         if (m_cnt > 0 && ($urandom % 2) == 1) st_addr = AW'(m_ea[(m_head + $urandom % m_cnt) % Q]);
         else st_addr = AW'($urandom);
         #1;
         model_step();
      end
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule